// File: doc/BRIEF.md
# Cycle-Stealing Serial DMA Requester

This block is the bus-master front end shared by six serial-channel DMA requesters. Each requester presents one transfer at a time: an address, a direction, its protocol mode, a 3-bit function code and, for writes, the data. The block picks one pending channel and obtains the shared 16-bit system bus. It then runs a single asynchronous-style bus cycle that ends on the data-transfer acknowledge. It gives up the bus right after that one cycle and reports completion to the channel that was served.

Normally the block raises an internal bus request and waits for the internal grant. Only then does it drive its grant-acknowledge output low. When the general-purpose DMA engine already owns the bus, the serial requesters take priority. The block slips its cycle in at once, with no request and no grant handshake. The transfer width follows from direction and mode: reads are always 16 bits, and writes are 8 bits except in the two bit-oriented framing modes. A watchdog closes any cycle that receives no acknowledge and reports a bus error.

Top module: `serial_dma_stealer`

## Requirements
- R1: Six independent request inputs are served. A requester keeps its request high until its own bit of `done_o` or `berr_o` pulses. Every channel index 0 to 5 can complete a transfer.
- R2: When the general-purpose engine does not own the bus, `bus_req_o` rises the cycle after a request is seen and stays high until `bus_gnt_i` is sampled high. `bgack_n_o` and `as_n_o` stay high until the cycle after that grant sample.
- R3: A bus cycle lasts until `dtack_n_i` is sampled low. In the next cycle `as_n_o`, both data strobes and `bgack_n_o` are high, `bus_req_o` is low, and the served channel's `done_o` bit is high. For a read, `rdata_o` then holds the captured `din_i`.
- R4: Requests are served in fixed priority, channel 0 first. When several channels are pending at a grant point, the lowest index is served and the others wait.
- R5: If `gp_owns_i` is high when a request is taken, `bus_req_o` stays low and the bus cycle (`bgack_n_o` and `as_n_o` low) starts in the very next cycle.
- R6: Every read (`ch_wr_i` bit = 0) is a 16-bit access: `rw_o` = 1, and `uds_n_o` and `lds_n_o` are both low.
- R7: A write in mode 2'b00 (character async) or 2'b11 (byte-oriented synchronous) is an 8-bit access. Address bit 0 = 0 asserts only `uds_n_o`, and address bit 0 = 1 asserts only `lds_n_o`. The low write byte is driven on both halves of `dout_o`.
- R8: A write in mode 2'b01 (HDLC) or 2'b10 (transparent) is a 16-bit access. Both strobes are low and `dout_o` carries the full 16-bit write word.
- R9: During a channel's cycle, `fc_o` carries that channel's 3-bit function code and `addr_o` carries address bits 23:1.
- R10: A 16-bit access with an odd address runs no bus cycle. The channel's `berr_o` bit pulses in the cycle after the request is taken, with `bus_req_o` and `as_n_o` inactive.
- R11: When `dtack_n_i` stays high, the cycle holds `as_n_o` low for exactly `max(wdog_limit_i,1)` cycles. It then ends, and the channel's `berr_o` bit pulses in the following cycle.
- R12: `done_o` and `berr_o` together have at most one bit high, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_req_i | input | 6 | Per-channel transfer request |
| ch_addr_i | input | 144 | Per-channel 24-bit byte address, channel c at bits 24c+23:24c |
| ch_wr_i | input | 6 | Per-channel direction, 1 = write |
| ch_mode_i | input | 12 | Per-channel protocol mode, 2 bits each |
| ch_fc_i | input | 18 | Per-channel function code, 3 bits each |
| ch_wdata_i | input | 96 | Per-channel write data, 16 bits each |
| wdog_limit_i | input | 16 | Cycles without acknowledge before a bus error |
| gp_owns_i | input | 1 | General-purpose DMA currently owns the bus |
| bus_req_o | output | 1 | Internal bus request |
| bus_gnt_i | input | 1 | Internal bus grant |
| bgack_n_o | output | 1 | Bus-grant acknowledge, active low |
| as_n_o | output | 1 | Address strobe, active low |
| uds_n_o | output | 1 | Upper data strobe, active low |
| lds_n_o | output | 1 | Lower data strobe, active low |
| rw_o | output | 1 | 1 = read, 0 = write |
| addr_o | output | 23 | Address bits 23:1 |
| fc_o | output | 3 | Function code of the active cycle |
| dout_o | output | 16 | Write data |
| din_i | input | 16 | Read data |
| dtack_n_i | input | 1 | Data-transfer acknowledge, active low |
| done_o | output | 6 | Per-channel completion pulse |
| berr_o | output | 6 | Per-channel bus-error pulse |
| rdata_o | output | 16 | Read data of the last completed read |

## Verification
The bench holds the grant low for an extra cycle. A design that drove the acknowledge before the grant would show `bgack_n_o` low too early. It also runs cycles while the general-purpose engine owns the bus, where a design that re-arbitrated would raise `bus_req_o` or start a cycle late. Simultaneous requests on channels 1 and 4 expose inverted or rotating priority through the function code and the done bit seen first. Byte writes at both address parities, word writes in both bit-oriented modes, and an odd-address word read catch swapped strobes, wrong sizing, and misaligned cycles that should never reach the bus. A withheld acknowledge with a limit of 5 counts strobe-low cycles exactly, so a watchdog that is off by one shows up.

// File: rtl/sds_pkg.sv
package sds_pkg;
  localparam int WDOG_W = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER, ST_GAP} sds_state_e;

  localparam logic [1:0] MODE_ASYNC  = 2'b00;
  localparam logic [1:0] MODE_HDLC   = 2'b01;
  localparam logic [1:0] MODE_TRANSP = 2'b10;
  localparam logic [1:0] MODE_BYTESY = 2'b11;

  // 16-bit access for every read and for bit-oriented framing writes
  function automatic logic is_word(input logic wr, input logic [1:0] mode);
    return !wr || (mode == MODE_HDLC) || (mode == MODE_TRANSP);
  endfunction

  // returns {uds_n, lds_n}
  function automatic logic [1:0] strobe_n(input logic word, input logic a0);
    if (word) return 2'b00;
    return a0 ? 2'b10 : 2'b01;
  endfunction

  function automatic logic misaligned(input logic word, input logic a0);
    return word && a0;
  endfunction

  // limit 0 behaves as limit 1
  function automatic logic wdog_hit(input logic [WDOG_W-1:0] cnt,
                                    input logic [WDOG_W-1:0] limit);
    return ({1'b0, cnt} + 1'b1) >= {1'b0, limit};
  endfunction
endpackage

// File: rtl/sds_prio.sv
module sds_prio #(
  parameter int NCH = 6,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] gnt,
  output logic [IW-1:0]  idx,
  output logic           any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sds_chmux.sv
module sds_chmux import sds_pkg::*; #(
  parameter int NCH = 6,
  parameter int AW  = 24,
  parameter int DW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [IW-1:0]     idx,
  input  logic [NCH*AW-1:0] ch_addr,
  input  logic [NCH-1:0]    ch_wr,
  input  logic [NCH*2-1:0]  ch_mode,
  input  logic [NCH*3-1:0]  ch_fc,
  input  logic [NCH*DW-1:0] ch_wdata,
  output logic [AW-1:0]     sel_addr,
  output logic              sel_wr,
  output logic              sel_word,
  output logic [2:0]        sel_fc,
  output logic [DW-1:0]     sel_wdata
);
  logic [1:0]    mode;
  logic [DW-1:0] raw;

  always_comb begin
    sel_addr  = ch_addr[idx*AW +: AW];
    sel_wr    = ch_wr[idx];
    mode      = ch_mode[idx*2 +: 2];
    sel_fc    = ch_fc[idx*3 +: 3];
    raw       = ch_wdata[idx*DW +: DW];
    sel_word  = is_word(sel_wr, mode);
    sel_wdata = sel_word ? raw : {2{raw[DW/2-1:0]}};
  end
endmodule

// File: rtl/sds_cycle.sv
module sds_cycle import sds_pkg::*; #(
  parameter int NCH = 6,
  parameter int AW  = 24,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_req,
  input  logic [NCH-1:0]    gnt,
  input  logic [AW-1:0]     sel_addr,
  input  logic              sel_wr,
  input  logic              sel_word,
  input  logic [2:0]        sel_fc,
  input  logic [DW-1:0]     sel_wdata,
  input  logic [WDOG_W-1:0] wdog_limit,
  input  logic              gp_owns,
  input  logic              bus_gnt,
  input  logic              dtack_n,
  input  logic [DW-1:0]     din,
  output logic              bus_req,
  output logic              bgack_n,
  output logic              as_n,
  output logic              uds_n,
  output logic              lds_n,
  output logic              rw,
  output logic [AW-1:1]     addr,
  output logic [2:0]        fc,
  output logic [DW-1:0]     dout,
  output logic [NCH-1:0]    done,
  output logic [NCH-1:0]    berr,
  output logic [DW-1:0]     rdata,
  output logic              ev_start,
  output logic              ev_end
);
  sds_state_e        state_q;
  logic [NCH-1:0]    cur_q, done_q, berr_q;
  logic [AW-1:0]     addr_q;
  logic              wr_q, word_q;
  logic [2:0]        fc_q;
  logic [DW-1:0]     wdata_q, rdata_q;
  logic [WDOG_W-1:0] cnt_q;
  logic              in_xfer, bad_align;

  assign in_xfer   = (state_q == ST_XFER);
  assign bad_align = misaligned(sel_word, sel_addr[0]);
  assign ev_start  = (state_q == ST_IDLE) && any_req && !bad_align;
  assign ev_end    = in_xfer && (!dtack_n || wdog_hit(cnt_q, wdog_limit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      done_q  <= '0;
      berr_q  <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      word_q  <= 1'b1;
      fc_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      cnt_q   <= '0;
    end else begin
      done_q <= '0;
      berr_q <= '0;
      unique case (state_q)
        ST_IDLE: if (any_req) begin
          cur_q   <= gnt;
          addr_q  <= sel_addr;
          wr_q    <= sel_wr;
          word_q  <= sel_word;
          fc_q    <= sel_fc;
          wdata_q <= sel_wdata;
          cnt_q   <= '0;
          if (bad_align) begin
            berr_q  <= gnt;
            state_q <= ST_GAP;
          end else if (gp_owns) begin
            state_q <= ST_XFER;
          end else begin
            state_q <= ST_REQ;
          end
        end
        ST_REQ: if (bus_gnt) state_q <= ST_XFER;
        ST_XFER: begin
          if (!dtack_n) begin
            done_q  <= cur_q;
            if (!wr_q) rdata_q <= din;
            state_q <= ST_GAP;
          end else if (wdog_hit(cnt_q, wdog_limit)) begin
            berr_q  <= cur_q;
            state_q <= ST_GAP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req        = (state_q == ST_REQ);
    bgack_n        = !in_xfer;
    as_n           = !in_xfer;
    {uds_n, lds_n} = in_xfer ? strobe_n(word_q, addr_q[0]) : 2'b11;
    rw             = in_xfer ? !wr_q : 1'b1;
    addr           = in_xfer ? addr_q[AW-1:1] : '0;
    fc             = in_xfer ? fc_q : '0;
    dout           = (in_xfer && wr_q) ? wdata_q : '0;
  end

  assign done  = done_q;
  assign berr  = berr_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/serial_dma_stealer.sv
module serial_dma_stealer import sds_pkg::*; #(
  parameter int NCH = 6,
  parameter int AW  = 24,
  parameter int DW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ch_req_i,
  input  logic [NCH*AW-1:0] ch_addr_i,
  input  logic [NCH-1:0]    ch_wr_i,
  input  logic [NCH*2-1:0]  ch_mode_i,
  input  logic [NCH*3-1:0]  ch_fc_i,
  input  logic [NCH*DW-1:0] ch_wdata_i,
  input  logic [WDOG_W-1:0] wdog_limit_i,
  input  logic              gp_owns_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              bgack_n_o,
  output logic              as_n_o,
  output logic              uds_n_o,
  output logic              lds_n_o,
  output logic              rw_o,
  output logic [AW-1:1]     addr_o,
  output logic [2:0]        fc_o,
  output logic [DW-1:0]     dout_o,
  input  logic [DW-1:0]     din_i,
  input  logic              dtack_n_i,
  output logic [NCH-1:0]    done_o,
  output logic [NCH-1:0]    berr_o,
  output logic [DW-1:0]     rdata_o
);
  logic [NCH-1:0] win_gnt;
  logic [IW-1:0]  win_idx;
  logic           win_any;
  logic [AW-1:0]  sel_addr;
  logic           sel_wr, sel_word;
  logic [2:0]     sel_fc;
  logic [DW-1:0]  sel_wdata;
  logic           ev_start, ev_end;

  sds_prio #(.NCH(NCH)) u_prio (
    .req(ch_req_i), .gnt(win_gnt), .idx(win_idx), .any(win_any)
  );

  sds_chmux #(.NCH(NCH), .AW(AW), .DW(DW)) u_mux (
    .idx(win_idx), .ch_addr(ch_addr_i), .ch_wr(ch_wr_i), .ch_mode(ch_mode_i),
    .ch_fc(ch_fc_i), .ch_wdata(ch_wdata_i), .sel_addr(sel_addr),
    .sel_wr(sel_wr), .sel_word(sel_word), .sel_fc(sel_fc), .sel_wdata(sel_wdata)
  );

  sds_cycle #(.NCH(NCH), .AW(AW), .DW(DW)) u_cyc (
    .clk(clk), .rst_n(rst_n), .any_req(win_any), .gnt(win_gnt),
    .sel_addr(sel_addr), .sel_wr(sel_wr), .sel_word(sel_word),
    .sel_fc(sel_fc), .sel_wdata(sel_wdata), .wdog_limit(wdog_limit_i),
    .gp_owns(gp_owns_i), .bus_gnt(bus_gnt_i), .dtack_n(dtack_n_i), .din(din_i),
    .bus_req(bus_req_o), .bgack_n(bgack_n_o), .as_n(as_n_o), .uds_n(uds_n_o),
    .lds_n(lds_n_o), .rw(rw_o), .addr(addr_o), .fc(fc_o), .dout(dout_o),
    .done(done_o), .berr(berr_o), .rdata(rdata_o),
    .ev_start(ev_start), .ev_end(ev_end)
  );
endmodule

// File: rtl/sds_checker.sv
module sds_checker import sds_pkg::*; #(
  parameter int NCH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic              gp_owns_i,
  input logic              bgack_n_o,
  input logic              as_n_o,
  input logic              uds_n_o,
  input logic              lds_n_o,
  input logic              rw_o,
  input logic              dtack_n_i,
  input logic [NCH-1:0]    done_o,
  input logic [NCH-1:0]    berr_o,
  input logic [WDOG_W-1:0] wdog_limit_i
);
  logic [WDOG_W:0] low_cnt;
  logic [WDOG_W:0] lim_eff;

  assign lim_eff = (wdog_limit_i == '0) ? (WDOG_W+1)'(1) : {1'b0, wdog_limit_i};

  always_ff @(posedge clk) begin
    if (!rst_n || as_n_o) low_cnt <= '0;
    else                  low_cnt <= low_cnt + 1'b1;
  end

  AST_ACK_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bgack_n_o) |-> ($past(bus_gnt_i) || $past(gp_owns_i))); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_gnt_i) |=> bus_req_o); // R2
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n_o && !dtack_n_i) |=> (as_n_o && bgack_n_o && !bus_req_o)); // R3
  AST_STEAL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_o) |-> !$past(gp_owns_i)); // R5
  AST_READ_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n_o && rw_o) |-> (!uds_n_o && !lds_n_o)); // R6
  AST_WDOG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n_o |-> (low_cnt < lim_eff)); // R11
  AST_ONE_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, berr_o})); // R12
  AST_REPORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|{done_o, berr_o}) |=> !(|{done_o, berr_o})); // R12
endmodule

bind serial_dma_stealer sds_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
  .gp_owns_i(gp_owns_i), .bgack_n_o(bgack_n_o), .as_n_o(as_n_o),
  .uds_n_o(uds_n_o), .lds_n_o(lds_n_o), .rw_o(rw_o), .dtack_n_i(dtack_n_i),
  .done_o(done_o), .berr_o(berr_o), .wdog_limit_i(wdog_limit_i)
);

// File: tb/serial_dma_stealer_tb.sv
`timescale 1ns/1ps
module serial_dma_stealer_tb;
  localparam int NCH = 6, AW = 24, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0]    ch_req = '0, ch_wr = '0;
  logic [NCH*AW-1:0] ch_addr = '0;
  logic [NCH*2-1:0]  ch_mode = '0;
  logic [NCH*3-1:0]  ch_fc = '0;
  logic [NCH*DW-1:0] ch_wdata = '0;
  logic [15:0]       wdog_limit = 16'd64;
  logic gp_owns = 1'b0, bus_gnt = 1'b0, dtack_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic bus_req, bgack_n, as_n, uds_n, lds_n, rw;
  logic [AW-1:1] addr;
  logic [2:0] fc;
  logic [DW-1:0] dout, rdata;
  logic [NCH-1:0] done, berr;

  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  serial_dma_stealer #(.NCH(NCH), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ch_req_i(ch_req), .ch_addr_i(ch_addr),
    .ch_wr_i(ch_wr), .ch_mode_i(ch_mode), .ch_fc_i(ch_fc), .ch_wdata_i(ch_wdata),
    .wdog_limit_i(wdog_limit), .gp_owns_i(gp_owns), .bus_req_o(bus_req),
    .bus_gnt_i(bus_gnt), .bgack_n_o(bgack_n), .as_n_o(as_n), .uds_n_o(uds_n),
    .lds_n_o(lds_n), .rw_o(rw), .addr_o(addr), .fc_o(fc), .dout_o(dout),
    .din_i(din), .dtack_n_i(dtack_n), .done_o(done), .berr_o(berr),
    .rdata_o(rdata)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_ch(input int c, input logic [23:0] a, input logic wr,
                        input logic [1:0] m, input logic [2:0] f, input logic [15:0] w);
    ch_addr[c*AW +: AW]  = a;
    ch_wr[c]             = wr;
    ch_mode[c*2 +: 2]    = m;
    ch_fc[c*3 +: 3]      = f;
    ch_wdata[c*DW +: DW] = w;
  endtask

  // acknowledge now, look at the report on the next falling edge, then release
  task automatic ack_and_report(input int c, input logic [15:0] d, input string tag);
    dtack_n = 1'b0; din = d;
    neg(1);
    eq({tag, " done bit"}, done, 32'(1) << c);
    eq({tag, " strobes released"}, {as_n, bgack_n, uds_n, lds_n, bus_req}, 5'b11110);
    ch_req[c] = 1'b0; dtack_n = 1'b1; bus_gnt = 1'b0;
    neg(1);
    eq({tag, " R12 done one cycle"}, done, 0);
  endtask

  task automatic t_reset();
    eq("R2 reset idle outputs", {bus_req, bgack_n, as_n, uds_n, lds_n}, 5'b01111);
    eq("R12 reset no reports", {done, berr}, 0);
  endtask

  task automatic t_normal_read();
    gp_owns = 1'b0;
    set_ch(2, 24'h001234, 1'b0, 2'b00, 3'd5, 16'h0);
    ch_req[2] = 1'b1;
    neg(1);
    eq("R2 request raised", {bus_req, bgack_n, as_n}, 3'b111);
    neg(1);
    eq("R2 no ack before grant", {bus_req, bgack_n, as_n}, 3'b111);
    bus_gnt = 1'b1;
    neg(1);
    eq("R2 ack after grant", {bgack_n, as_n}, 2'b00);
    eq("R6 read both strobes", {rw, uds_n, lds_n}, 3'b100);
    eq("R9 fc ch2", fc, 3'd5);
    eq("R9 address", addr, 24'h001234 >> 1);
    ack_and_report(2, 16'hBEEF, "R3 read");
    eq("R3 read data", rdata, 16'hBEEF);
  endtask

  task automatic t_byte_writes();
    gp_owns = 1'b1;
    set_ch(3, 24'h000101, 1'b1, 2'b00, 3'd2, 16'h12A5);
    ch_req[3] = 1'b1;
    neg(1);
    eq("R5 steal starts next cycle", {bus_req, bgack_n, as_n}, 3'b000);
    eq("R7 odd byte lower strobe", {rw, uds_n, lds_n}, 3'b010);
    eq("R7 byte replicated", dout, 16'hA5A5);
    ack_and_report(3, 16'h0, "R7 odd");
    set_ch(1, 24'h000200, 1'b1, 2'b11, 3'd6, 16'hFF3C);
    ch_req[1] = 1'b1;
    neg(1);
    eq("R5 steal no request", {bus_req, as_n}, 2'b00);
    eq("R7 even byte upper strobe", {rw, uds_n, lds_n}, 3'b001);
    eq("R7 even byte data", dout, 16'h3C3C);
    ack_and_report(1, 16'h0, "R7 even");
    gp_owns = 1'b0;
  endtask

  task automatic t_word_writes();
    gp_owns = 1'b1;
    set_ch(0, 24'h000400, 1'b1, 2'b01, 3'd1, 16'hC33C);
    ch_req[0] = 1'b1;
    neg(1);
    eq("R8 HDLC word strobes", {as_n, rw, uds_n, lds_n}, 4'b0000);
    eq("R8 HDLC word data", dout, 16'hC33C);
    ack_and_report(0, 16'h0, "R8 hdlc");
    set_ch(5, 24'h000402, 1'b1, 2'b10, 3'd7, 16'h5A96);
    ch_req[5] = 1'b1;
    neg(1);
    eq("R8 transparent word strobes", {as_n, rw, uds_n, lds_n}, 4'b0000);
    eq("R8 transparent word data", dout, 16'h5A96);
    ack_and_report(5, 16'h0, "R8 transp");
    gp_owns = 1'b0;
  endtask

  task automatic t_priority();
    gp_owns = 1'b1;
    set_ch(4, 24'h000010, 1'b0, 2'b00, 3'd4, 16'h0);
    set_ch(1, 24'h000020, 1'b0, 2'b00, 3'd3, 16'h0);
    ch_req[4] = 1'b1; ch_req[1] = 1'b1;
    neg(1);
    eq("R4 lower index first fc", fc, 3'd3);
    ack_and_report(1, 16'h1111, "R4 first");
    eq("R4 waiting channel idle gap", as_n, 1'b1);
    neg(1);
    eq("R4 second channel fc", {as_n, fc}, {1'b0, 3'd4});
    ack_and_report(4, 16'h4444, "R4 second");
    eq("R4 second read data", rdata, 16'h4444);
    gp_owns = 1'b0;
  endtask

  task automatic t_all_channels();
    gp_owns = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      set_ch(c, 24'(32'h100 + 2*c), 1'b0, 2'b00, 3'(c + 1), 16'h0);
      ch_req[c] = 1'b1;
      neg(1);
      eq("R1 channel cycle fc", {as_n, fc}, {1'b0, 3'(c + 1)});
      ack_and_report(c, 16'(c), "R1 channel");
    end
    gp_owns = 1'b0;
  endtask

  task automatic t_misaligned();
    gp_owns = 1'b0;
    set_ch(2, 24'h000333, 1'b0, 2'b00, 3'd5, 16'h0);
    ch_req[2] = 1'b1;
    neg(1);
    eq("R10 odd word bus error", berr, 6'b000100);
    eq("R10 no bus cycle", {bus_req, as_n, bgack_n, done}, {3'b011, 6'b0});
    ch_req[2] = 1'b0;
    neg(1);
    eq("R10 no request after", {bus_req, as_n, berr}, {2'b01, 6'b0});
  endtask

  task automatic t_watchdog();
    int lowcnt = 0;
    gp_owns = 1'b1;
    wdog_limit = 16'd5;
    set_ch(0, 24'h000800, 1'b0, 2'b00, 3'd2, 16'h0);
    ch_req[0] = 1'b1;
    neg(1);
    while (!as_n && lowcnt < 50) begin
      lowcnt++;
      neg(1);
    end
    eq("R11 strobe-low cycles", lowcnt, 5);
    eq("R11 bus error bit", berr, 6'b000001);
    eq("R11 no done", done, 0);
    ch_req[0] = 1'b0;
    neg(1);
    eq("R12 berr one cycle", berr, 0);
    wdog_limit = 16'd64;
    gp_owns = 1'b0;
  endtask

  initial begin
    neg(3);
    rst_n = 1'b1;
    neg(1);
    t_reset();
    t_normal_read();
    t_byte_writes();
    t_word_writes();
    t_priority();
    t_all_channels();
    t_misaligned();
    t_watchdog();
    neg(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule